// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Aligner with Automatic Interworking

This block sits behind an E1 basic frame aligner. Once basic alignment is held, it searches the stream of NFAS bit-1 values for the six-bit CRC-4 multiframe alignment word. It then confirms a second word one multiframe later and declares CRC-4 multiframe sync. The basic aligner supplies one strobe per received 125 µs frame, an odd/even indication (odd frames carry the NFAS word), the bit-1 value of timeslot 0, and its lock flag.

The far end may lack CRC-4 capability. With automatic interworking enabled (control input low), a search that has not locked within a frame-count timeout declares the far end non-CRC-4. In that state receive CRC-4 checking is turned off, the transmitter is told to send CRC-4 with its E bits forced to zero, and a status flag is raised. With interworking disabled, the search simply continues. Computing the CRC itself is done elsewhere.

Top module: `crc4_mf_align`

## Requirements
- R1: After reset, `crc_sync_n` is 1, `crc_frm_num` is 0, and `rx_crc_en`, `tx_ebit_zero` and `far_noncrc` are 0.
- R2: The alignment word is 001011, oldest bit first, taken from `nfas_b1` in six consecutive odd (`frm_odd`=1) frames that fall in frames 1, 3, 5, 7, 9 and 11. On the strobe that completes a first word, `crc_frm_num` becomes 11 while `crc_sync_n` stays 1.
- R3: If the odd frame exactly 16 frames later completes a second word, `crc_sync_n` goes low and `rx_crc_en` goes high one clock after that strobe, with `crc_frm_num` = 11.
- R4: If that frame does not complete a word, the search restarts (`crc_frm_num` back to 0, no sync), and a later valid pair still brings sync.
- R5: While `bas_lock` is low, frames are ignored and all outputs keep their reset values.
- R6: From the first word onward, `crc_frm_num` advances by one, modulo 16, on every frame strobe. While searching with no word found, it reads 0.
- R7: With `auto_iw_n` low, if `TIMEOUT_FRAMES` strobes (default 3200 = 400 ms) pass after `bas_lock` rises without sync, then within two clocks of the last strobe `far_noncrc` and `tx_ebit_zero` go high, while `rx_crc_en` stays low and `crc_sync_n` stays high. The search then stops (later words are ignored) until `bas_lock` falls.
- R8: With `auto_iw_n` high there is no fallback, and the search can still lock after the timeout. Lowering `auto_iw_n` after an expired, unlocked timeout raises `far_noncrc` within two clocks.
- R9: Once CRC-4 sync is reached, no fallback occurs however long basic lock is held.
- R10: One clock after `bas_lock` is low, sync, frame number, timeout count and non-CRC-4 status are all cleared.
- R11: `nfas_b1` values on even frames have no effect on the search. The E-bit positions (frames 13 and 15) may carry 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bas_lock | input | 1 | Basic frame alignment held |
| frm_stb | input | 1 | One-clock pulse per received frame |
| frm_odd | input | 1 | Current frame carries the NFAS word |
| nfas_b1 | input | 1 | Bit 1 of timeslot 0 for the current frame |
| auto_iw_n | input | 1 | 0 enables automatic interworking fallback |
| crc_sync_n | output | 1 | CRC-4 multiframe sync, active low |
| crc_frm_num | output | 4 | Frame number within the CRC-4 multiframe |
| rx_crc_en | output | 1 | Receive CRC-4 checking enabled |
| tx_ebit_zero | output | 1 | Transmitter must send E bits as zero |
| far_noncrc | output | 1 | Far end declared non-CRC-4 |

## Verification
The search is driven with whole multiframes whose NFAS bits vary between scenarios. These include two clean words, a clean word followed by a corrupted or missing one, a lone second word, E bits at 0 and at 1, and even-frame bits set to 1. Together they separate a true two-word confirmation from a single match or a false restart. A sequence of good, bad, good, good multiframes shows that the search recovers at the next candidate. Long runs of all-zero frames, with interworking on and off, locate the timeout edge to the exact strobe. They also show that sync outranks fallback, and that the late lowering of the control input and the loss of basic lock act as required.

// File: rtl/crc4mf_pkg.sv
package crc4mf_pkg;

    // CRC-4 multiframe geometry
    localparam int unsigned MF_FRAMES = 16;
    localparam int unsigned POS_W     = $clog2(MF_FRAMES);
    localparam int unsigned WORD_W    = 6;
    localparam logic [WORD_W-1:0] MF_WORD = 6'b001011;
    // frame number carried by the NFAS frame holding the last word bit
    localparam logic [POS_W-1:0] WORD_END_POS = POS_W'(11);

    typedef enum logic [1:0] {
        MF_HUNT    = 2'd0,
        MF_CONFIRM = 2'd1,
        MF_LOCKED  = 2'd2
    } mf_state_e;

    typedef struct packed {
        mf_state_e        st;
        logic [POS_W-1:0] pos;
        logic             noncrc;
    } mf_reg_t;

endpackage

// File: rtl/crc4_word_det.sv
module crc4_word_det #(
    parameter int unsigned     W   = 6,
    parameter logic [W-1:0]    PAT = 6'b001011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift_en,
    input  logic bit_in,
    output logic hit
);
    localparam int unsigned CW = $clog2(W);

    typedef struct packed {
        logic [W-2:0]  sr;
        logic [CW-1:0] fill;
    } det_reg_t;

    det_reg_t cur_q, nxt_d;
    logic [W-1:0] window;

    always_comb begin
        window = {cur_q.sr, bit_in};
        hit    = shift_en && (cur_q.fill == CW'(W-1)) && (window == PAT);
        nxt_d  = cur_q;
        if (clr) begin
            nxt_d = '0;
        end else if (shift_en) begin
            nxt_d.sr = window[W-2:0];
            if (cur_q.fill != CW'(W-1)) begin
                nxt_d.fill = cur_q.fill + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/crc4_iw_timer.sv
module crc4_iw_timer #(
    parameter int unsigned LIMIT = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cnt_en,
    output logic expired
);
    localparam int unsigned TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        expired = (cnt_q == TW'(LIMIT));
        cnt_d   = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_en && !expired) begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/crc4_mf_align.sv
module crc4_mf_align
    import crc4mf_pkg::*;
#(
    parameter int unsigned TIMEOUT_FRAMES = 3200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bas_lock,
    input  logic             frm_stb,
    input  logic             frm_odd,
    input  logic             nfas_b1,
    input  logic             auto_iw_n,
    output logic             crc_sync_n,
    output logic [POS_W-1:0] crc_frm_num,
    output logic             rx_crc_en,
    output logic             tx_ebit_zero,
    output logic             far_noncrc
);
    localparam logic [POS_W-1:0] CHECK_POS = WORD_END_POS - POS_W'(1);

    mf_reg_t cur_q, nxt_d;
    logic    word_hit;
    logic    tmr_expired;
    logic    tmr_en;
    logic    nfas_shift;

    assign nfas_shift = frm_stb && frm_odd && bas_lock;
    assign tmr_en     = frm_stb && (cur_q.st != MF_LOCKED) && !cur_q.noncrc;

    crc4_word_det #(
        .W   (WORD_W),
        .PAT (MF_WORD)
    ) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!bas_lock),
        .shift_en (nfas_shift),
        .bit_in   (nfas_b1),
        .hit      (word_hit)
    );

    crc4_iw_timer #(
        .LIMIT (TIMEOUT_FRAMES)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!bas_lock),
        .cnt_en  (tmr_en),
        .expired (tmr_expired)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!bas_lock) begin
            nxt_d = '0;
        end else begin
            if (frm_stb) begin
                case (cur_q.st)
                    MF_HUNT: begin
                        if (word_hit && !cur_q.noncrc) begin
                            nxt_d.st  = MF_CONFIRM;
                            nxt_d.pos = WORD_END_POS;
                        end
                    end
                    MF_CONFIRM: begin
                        nxt_d.pos = cur_q.pos + POS_W'(1);
                        if (cur_q.pos == CHECK_POS) begin
                            if (word_hit) begin
                                nxt_d.st = MF_LOCKED;
                            end else begin
                                nxt_d.st  = MF_HUNT;
                                nxt_d.pos = '0;
                            end
                        end
                    end
                    MF_LOCKED: begin
                        nxt_d.pos = cur_q.pos + POS_W'(1);
                    end
                    default: begin
                        nxt_d.st  = MF_HUNT;
                        nxt_d.pos = '0;
                    end
                endcase
            end
            if (!cur_q.noncrc && tmr_expired && !auto_iw_n &&
                (nxt_d.st != MF_LOCKED)) begin
                nxt_d.noncrc = 1'b1;
                nxt_d.st     = MF_HUNT;
                nxt_d.pos    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign crc_sync_n   = (cur_q.st != MF_LOCKED);
    assign rx_crc_en    = (cur_q.st == MF_LOCKED);
    assign crc_frm_num  = cur_q.pos;
    assign tx_ebit_zero = cur_q.noncrc;
    assign far_noncrc   = cur_q.noncrc;
endmodule

// File: rtl/crc4_mf_align_chk.sv
module crc4_mf_align_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bas_lock,
    input logic       frm_stb,
    input logic       nfas_b1,
    input logic       auto_iw_n,
    input logic       crc_sync_n,
    input logic [3:0] crc_frm_num,
    input logic       rx_crc_en,
    input logic       tx_ebit_zero,
    input logic       far_noncrc
);
    assert_lock_loss_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bas_lock |=> (crc_sync_n && !far_noncrc && !tx_ebit_zero && crc_frm_num == 4'd0));

    assert_sync_at_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_sync_n) |-> (crc_frm_num == 4'd11 && $past(frm_stb) && $past(nfas_b1)));

    assert_frame_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bas_lock && frm_stb && !crc_sync_n) |=> (crc_frm_num == $past(crc_frm_num) + 4'd1));

    assert_fallback_needs_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(far_noncrc) |-> !$past(auto_iw_n));

    assert_noncrc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        far_noncrc |-> (crc_sync_n && !rx_crc_en && tx_ebit_zero));

    assert_noncrc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (far_noncrc && bas_lock) |=> far_noncrc);
endmodule

bind crc4_mf_align crc4_mf_align_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bas_lock     (bas_lock),
    .frm_stb      (frm_stb),
    .nfas_b1      (nfas_b1),
    .auto_iw_n    (auto_iw_n),
    .crc_sync_n   (crc_sync_n),
    .crc_frm_num  (crc_frm_num),
    .rx_crc_en    (rx_crc_en),
    .tx_ebit_zero (tx_ebit_zero),
    .far_noncrc   (far_noncrc)
);

// File: tb/tb_crc4_mf_align.sv
module tb_crc4_mf_align;
    localparam int unsigned TMO = 3200;
    localparam int unsigned NVEC = 6;
    localparam logic [7:0] GOOD = 8'b00101111;

    // {mf1 NFAS bits (frame1..15), mf2 NFAS bits, even-frame bit, sync expected, num after mf1, num after mf2}
    localparam logic [25:0] VEC [NVEC] = '{
        {8'b00101111, 8'b00101111, 1'b0, 1'b1, 4'd15, 4'd15},
        {8'b00101111, 8'b00101111, 1'b1, 1'b1, 4'd15, 4'd15},
        {8'b00101111, 8'b00000011, 1'b0, 1'b0, 4'd15, 4'd0 },
        {8'b00101100, 8'b00101100, 1'b1, 1'b1, 4'd15, 4'd15},
        {8'b00101111, 8'b00111111, 1'b0, 1'b0, 4'd15, 4'd0 },
        {8'b11111111, 8'b00101111, 1'b0, 1'b0, 4'd0,  4'd15}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bas_lock = 1'b0;
    logic       frm_stb = 1'b0;
    logic       frm_odd = 1'b0;
    logic       nfas_b1 = 1'b0;
    logic       auto_iw_n = 1'b0;
    logic       crc_sync_n;
    logic [3:0] crc_frm_num;
    logic       rx_crc_en;
    logic       tx_ebit_zero;
    logic       far_noncrc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    crc4_mf_align #(.TIMEOUT_FRAMES(TMO)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bas_lock     (bas_lock),
        .frm_stb      (frm_stb),
        .frm_odd      (frm_odd),
        .nfas_b1      (nfas_b1),
        .auto_iw_n    (auto_iw_n),
        .crc_sync_n   (crc_sync_n),
        .crc_frm_num  (crc_frm_num),
        .rx_crc_en    (rx_crc_en),
        .tx_ebit_zero (tx_ebit_zero),
        .far_noncrc   (far_noncrc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic odd, input logic b);
        @(negedge clk);
        frm_stb = 1'b1;
        frm_odd = odd;
        nfas_b1 = b;
        @(negedge clk);
        frm_stb = 1'b0;
    endtask

    task automatic send_mf(input logic [7:0] w, input logic evenb);
        for (int f = 0; f < 16; f++) begin
            if (f % 2 == 1) send_frame(1'b1, w[7 - f/2]);
            else            send_frame(1'b0, evenb);
        end
    endtask

    task automatic relock();
        @(negedge clk);
        bas_lock = 1'b0;
        repeat (2) @(negedge clk);
        bas_lock = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 sync_n", 32'(crc_sync_n), 32'd1);
        check("R1 num", 32'(crc_frm_num), 32'd0);
        check("R1 flags", {29'd0, rx_crc_en, tx_ebit_zero, far_noncrc}, 32'd0);
        rst_n = 1'b1;

        // R5: without basic lock, good words are ignored
        send_mf(GOOD, 1'b0);
        send_mf(GOOD, 1'b0);
        check("R5 sync_n", 32'(crc_sync_n), 32'd1);
        check("R5 num", 32'(crc_frm_num), 32'd0);

        // Vector table: R2, R3, R4, R11
        for (int v = 0; v < NVEC; v++) begin
            relock();
            send_mf(VEC[v][25:18], VEC[v][9]);
            check($sformatf("R2 vec%0d num mf1", v), 32'(crc_frm_num), 32'(VEC[v][7:4]));
            check($sformatf("R2 vec%0d sync_n mf1", v), 32'(crc_sync_n), 32'd1);
            send_mf(VEC[v][17:10], VEC[v][9]);
            check($sformatf("R3 R11 vec%0d sync_n", v), 32'(crc_sync_n), 32'(!VEC[v][8]));
            check($sformatf("R3 vec%0d rx_en", v), 32'(rx_crc_en), 32'(VEC[v][8]));
            check($sformatf("R4 vec%0d num mf2", v), 32'(crc_frm_num), 32'(VEC[v][3:0]));
        end

        // R3 / R6: exact sync strobe and number wrap
        relock();
        send_mf(GOOD, 1'b0);
        for (int f = 0; f < 11; f++) send_frame(f[0], (f % 2 == 1) ? GOOD[7 - f/2] : 1'b0);
        check("R3 not yet synced", 32'(crc_sync_n), 32'd1);
        send_frame(1'b1, GOOD[2]);
        check("R3 synced at frame 11", 32'(crc_sync_n), 32'd0);
        check("R3 num 11", 32'(crc_frm_num), 32'd11);
        for (int f = 12; f < 16; f++) send_frame(f[0], (f % 2 == 1) ? GOOD[7 - f/2] : 1'b0);
        send_frame(1'b0, 1'b0);
        check("R6 num wraps to 0", 32'(crc_frm_num), 32'd0);

        // R4: good, bad, good, good
        relock();
        send_mf(GOOD, 1'b0);
        send_mf(8'b00000000, 1'b0);
        check("R4 restart num", 32'(crc_frm_num), 32'd0);
        send_mf(GOOD, 1'b0);
        check("R4 not synced after one", 32'(crc_sync_n), 32'd1);
        send_mf(GOOD, 1'b0);
        check("R4 synced on later pair", 32'(crc_sync_n), 32'd0);

        // R7: timeout with interworking enabled
        auto_iw_n = 1'b0;
        relock();
        for (int m = 0; m < 199; m++) send_mf(8'h00, 1'b0);
        for (int f = 0; f < 15; f++) send_frame(f[0], 1'b0);
        @(negedge clk);
        check("R7 no fallback before limit", 32'(far_noncrc), 32'd0);
        send_frame(1'b1, 1'b0);
        @(negedge clk);
        check("R7 far_noncrc", 32'(far_noncrc), 32'd1);
        check("R7 tx_ebit_zero", 32'(tx_ebit_zero), 32'd1);
        check("R7 rx_en off", 32'(rx_crc_en), 32'd0);
        send_mf(GOOD, 1'b0);
        send_mf(GOOD, 1'b0);
        check("R7 search halted", 32'(crc_sync_n), 32'd1);

        // R10: lock loss clears status
        @(negedge clk);
        bas_lock = 1'b0;
        @(negedge clk);
        check("R10 far_noncrc cleared", 32'(far_noncrc), 32'd0);
        check("R10 ebit cleared", 32'(tx_ebit_zero), 32'd0);

        // R8: interworking disabled
        auto_iw_n = 1'b1;
        relock();
        for (int m = 0; m < 205; m++) send_mf(8'h00, 1'b0);
        @(negedge clk);
        check("R8 no fallback when disabled", 32'(far_noncrc), 32'd0);
        @(negedge clk);
        auto_iw_n = 1'b0;
        @(negedge clk);
        check("R8 fallback on enable", 32'(far_noncrc), 32'd1);
        auto_iw_n = 1'b1;
        relock();
        for (int m = 0; m < 205; m++) send_mf(8'h00, 1'b0);
        send_mf(GOOD, 1'b0);
        send_mf(GOOD, 1'b0);
        check("R8 late sync", 32'(crc_sync_n), 32'd0);

        // R9: sync before timeout, then hold lock past it
        auto_iw_n = 1'b0;
        relock();
        send_mf(GOOD, 1'b0);
        send_mf(GOOD, 1'b0);
        for (int m = 0; m < 205; m++) send_mf(GOOD, 1'b1);
        @(negedge clk);
        check("R9 no fallback", 32'(far_noncrc), 32'd0);
        check("R9 still synced", 32'(crc_sync_n), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule